// File: doc/BRIEF.md
# Multi-mode fixed-point rounding unit

This block takes a fixed-point word and removes its lowest `DROP_W` bits, giving a shorter word that is rounded by one of six rules. The caller picks the rule for each sample with a 3-bit code. A separate select says whether the word is two's-complement signed or unsigned. The removed bits are treated as a fraction below the least significant kept bit. Setting `DROP_W` to the number of fractional bits gives a result aligned to whole numbers. A smaller `DROP_W` keeps some fractional bits.

The rounding rules are: up toward plus infinity, toward zero, down toward minus infinity, and three round-to-nearest rules. The nearest rules differ only in how an exact half-way tie is settled: away from zero, toward plus infinity, or to the even neighbour. Rounding can only move a result upward. If the upward step would pass the largest kept value, the result is clamped to that value and an overflow flag is raised for that sample. The output word, the valid strobe and the overflow flag are registered, so every accepted sample produces its result one clock later.

Top module: `fxp_round_unit`

## Requirements
- R1: `valid_o` is `valid_i` delayed by exactly one clock, and `data_o`/`ovf_o` in that cycle belong to the sample accepted with it.
- R2: Mode code 0 rounds toward plus infinity: the kept part is incremented whenever any dropped bit is 1.
- R3: Mode code 1 rounds toward zero: for a signed negative input with any dropped bit set, the kept part is incremented; otherwise it is truncated.
- R4: Mode code 2 rounds toward minus infinity (plain truncation of the dropped bits); codes 6 and 7 behave the same.
- R5: Mode code 3 rounds to nearest; an exact tie (top dropped bit 1, all lower dropped bits 0) goes away from zero.
- R6: Mode code 4 rounds to nearest; an exact tie always goes toward plus infinity.
- R7: Mode code 5 rounds to nearest; an exact tie goes to the neighbour whose least significant kept bit is 0.
- R8: With `signed_i` = 0 the input is treated as unsigned (never negative), so codes 1 and 2 give identical truncated results.
- R9: If incrementing would exceed the largest kept value (0x7FF for signed, 0xFFF for unsigned at default widths), `data_o` takes that largest value and `ovf_o` is 1 for that cycle only.
- R10: While `rst_ni` is low, `valid_o` and `ovf_o` are 0 and `data_o` is 0.
- R11: A cycle with `valid_i` = 0 leaves `data_o` unchanged and drives `ovf_o` to 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample strobe |
| data_i | input | DATA_W | Fixed-point input word |
| signed_i | input | 1 | 1: two's-complement input, 0: unsigned |
| mode_i | input | 3 | Rounding rule code (0..5; 6, 7 act as code 2) |
| valid_o | output | 1 | Result strobe, one clock after `valid_i` |
| data_o | output | DATA_W-DROP_W | Rounded result |
| ovf_o | output | 1 | Result clamped at its maximum |

## Verification
The assertions compare the outputs with the inputs seen one clock earlier. They assume `data_i`, `signed_i` and `mode_i` are stable around the clock edge at which `valid_i` is sampled. The bench drives every input on the falling edge and holds it until the next falling edge, so this assumption always holds. The random stimulus draws all eight mode codes and both signedness settings. About one word in four is forced to sit just below the top of the range or exactly on a half-way point, so the saturation and tie paths are exercised often.

// File: rtl/fxp_round_pkg.sv
package fxp_round_pkg;
  typedef enum logic [2:0] {
    RM_UP    = 3'd0,
    RM_ZERO  = 3'd1,
    RM_DOWN  = 3'd2,
    RM_AWAY  = 3'd3,
    RM_HALFP = 3'd4,
    RM_EVEN  = 3'd5
  } rnd_mode_e;
endpackage

// File: rtl/fxp_round_bits.sv
module fxp_round_bits #(
  parameter int DROP_W = 4
) (
  input  logic [DROP_W-1:0] frac_i,
  output logic              guard_o,
  output logic              sticky_o
);
  assign guard_o = frac_i[DROP_W-1];
  generate
    if (DROP_W == 1) begin : g_nosticky
      assign sticky_o = 1'b0;
    end else begin : g_sticky
      assign sticky_o = |frac_i[DROP_W-2:0];
    end
  endgenerate
endmodule

// File: rtl/fxp_round_decide.sv
module fxp_round_decide
  import fxp_round_pkg::*;
(
  input  logic [2:0] mode_i,
  input  logic       neg_i,
  input  logic       lsb_i,
  input  logic       guard_i,
  input  logic       sticky_i,
  output logic       inc_o
);
  logic inexact;
  assign inexact = guard_i | sticky_i;

  always_comb begin
    unique case (mode_i)
      RM_UP:    inc_o = inexact;
      RM_ZERO:  inc_o = neg_i & inexact;
      RM_AWAY:  inc_o = guard_i & (sticky_i | ~neg_i);
      RM_HALFP: inc_o = guard_i;
      RM_EVEN:  inc_o = guard_i & (sticky_i | lsb_i);
      default:  inc_o = 1'b0;  // down, and codes 6/7
    endcase
  end
endmodule

// File: rtl/fxp_round_satinc.sv
module fxp_round_satinc #(
  parameter int OUT_W = 12
) (
  input  logic [OUT_W-1:0] kept_i,
  input  logic             signed_i,
  input  logic             inc_i,
  output logic [OUT_W-1:0] res_o,
  output logic             ovf_o
);
  logic [OUT_W-1:0] max_val;
  assign max_val = signed_i ? {1'b0, {(OUT_W-1){1'b1}}} : {OUT_W{1'b1}};
  assign ovf_o   = inc_i & (kept_i == max_val);
  assign res_o   = ovf_o ? max_val : kept_i + {{(OUT_W-1){1'b0}}, inc_i};
endmodule

// File: rtl/fxp_round_unit.sv
module fxp_round_unit #(
  parameter int DATA_W = 16,
  parameter int DROP_W = 4,
  localparam int OUT_W = DATA_W - DROP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              signed_i,
  input  logic [2:0]        mode_i,
  output logic              valid_o,
  output logic [OUT_W-1:0]  data_o,
  output logic              ovf_o
);
  logic [OUT_W-1:0] kept, res;
  logic guard, sticky, neg, inc, ovf;

  assign kept = data_i[DATA_W-1:DROP_W];
  assign neg  = signed_i & data_i[DATA_W-1];

  fxp_round_bits #(.DROP_W(DROP_W)) u_bits (
    .frac_i  (data_i[DROP_W-1:0]),
    .guard_o (guard),
    .sticky_o(sticky)
  );

  fxp_round_decide u_dec (
    .mode_i  (mode_i),
    .neg_i   (neg),
    .lsb_i   (kept[0]),
    .guard_i (guard),
    .sticky_i(sticky),
    .inc_o   (inc)
  );

  fxp_round_satinc #(.OUT_W(OUT_W)) u_inc (
    .kept_i  (kept),
    .signed_i(signed_i),
    .inc_i   (inc),
    .res_o   (res),
    .ovf_o   (ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      ovf_o   <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      ovf_o   <= valid_i & ovf;
      if (valid_i) data_o <= res;
    end
  end
endmodule

// File: rtl/fxp_round_unit_chk.sv
module fxp_round_unit_chk #(
  parameter int DATA_W = 16,
  parameter int DROP_W = 4,
  localparam int OUT_W = DATA_W - DROP_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [DATA_W-1:0] data_i,
  input logic              signed_i,
  input logic [2:0]        mode_i,
  input logic              valid_o,
  input logic [OUT_W-1:0]  data_o,
  input logic              ovf_o
);
  localparam logic [OUT_W-1:0] SMAX = {1'b0, {(OUT_W-1){1'b1}}};

  // R1
  valid_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R1
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R4
  down_trunc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (mode_i == 3'd2 || mode_i >= 3'd6))
      |=> (data_o == $past(data_i[DATA_W-1:DROP_W])) && !ovf_o);
  // R8
  unsigned_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !signed_i && mode_i == 3'd1)
      |=> (data_o == $past(data_i[DATA_W-1:DROP_W])) && !ovf_o);
  // R9
  ovf_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> valid_o && (data_o == ($past(signed_i) ? SMAX : {OUT_W{1'b1}})));
  // R11
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o) && !ovf_o);
endmodule

bind fxp_round_unit fxp_round_unit_chk #(.DATA_W(DATA_W), .DROP_W(DROP_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
  .signed_i(signed_i), .mode_i(mode_i), .valid_o(valid_o), .data_o(data_o),
  .ovf_o(ovf_o)
);

// File: tb/tb_fxp_round_unit.sv
`timescale 1ns/1ps
module tb_fxp_round_unit;
  localparam int DW = 16;
  localparam int DR = 4;
  localparam int OW = DW - DR;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [DW-1:0] data_i = '0;
  logic signed_i = 1'b0;
  logic [2:0] mode_i = '0;
  logic valid_o, ovf_o;
  logic [OW-1:0] data_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  fxp_round_unit #(.DATA_W(DW), .DROP_W(DR)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .signed_i(signed_i), .mode_i(mode_i), .valid_o(valid_o), .data_o(data_o),
    .ovf_o(ovf_o)
  );

  function automatic string tag_of(input logic [2:0] m, input logic sg);
    if (!sg && (m == 3'd1 || m == 3'd2)) return "R8";
    case (m)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R4";
    endcase
  endfunction

  function automatic void model(input logic [DW-1:0] d, input logic sg, input logic [2:0] m,
                                output logic [OW-1:0] r, output logic ov);
    longint v, k, f, half, res, top;
    bit neg, above, tie, inexact, up;
    v = sg ? longint'($signed(d)) : longint'(d);
    k = v >>> DR;
    f = v - k * (64'sd1 <<< DR);
    half = 64'sd1 <<< (DR - 1);
    neg = (v < 0);
    above = (f > half);
    tie = (f == half);
    inexact = (f != 0);
    case (m)
      3'd0: up = inexact;
      3'd1: up = neg && inexact;
      3'd3: up = above || (tie && !neg);
      3'd4: up = above || tie;
      3'd5: up = above || (tie && (k % 2 != 0));
      default: up = 0;
    endcase
    top = sg ? (64'sd1 <<< (OW - 1)) - 1 : (64'sd1 <<< OW) - 1;
    res = k + (up ? 1 : 0);
    ov = (res > top);
    if (ov) res = top;
    r = res[OW-1:0];
  endfunction

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  logic [OW-1:0] exp_d = '0;
  logic exp_v = 0, exp_o = 0;
  string exp_tag = "R10";

  // Compare previous sample's result, then drive a new one (all at negedge).
  task automatic step(input logic v, input logic [DW-1:0] d, input logic sg, input logic [2:0] m);
    logic [OW-1:0] r;
    logic ov;
    @(negedge clk_i);
    check("R1", "valid_o", valid_o, exp_v);
    check(exp_v ? exp_tag : "R11", "data_o", data_o, exp_d);
    check(exp_o ? "R9" : (exp_v ? exp_tag : "R11"), "ovf_o", ovf_o, exp_o);
    valid_i = v; data_i = d; signed_i = sg; mode_i = m;
    model(d, sg, m, r, ov);
    exp_v = v;
    if (v) begin
      exp_d = r; exp_o = ov; exp_tag = ov ? "R9" : tag_of(m, sg);
    end else begin
      exp_o = 0;
    end
  endtask

  initial begin
    repeat (2000000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk_i);
    check("R10", "valid_o", valid_o, 0);
    check("R10", "ovf_o", ovf_o, 0);
    check("R10", "data_o", data_o, 0);
    rst_ni = 1'b1;
    // directed ties and corners, signed: 2.5, -2.5, 3.5, -3.5, 2.25, -2.25
    for (int m = 0; m < 8; m++) begin
      step(1, 16'h0028, 1, m[2:0]);
      step(1, 16'hFFD8, 1, m[2:0]);
      step(1, 16'h0038, 1, m[2:0]);
      step(1, 16'hFFC8, 1, m[2:0]);
      step(1, 16'h0024, 1, m[2:0]);
      step(1, 16'hFFDC, 1, m[2:0]);
      step(1, 16'h7FF8, 1, m[2:0]);  // saturation at signed top
      step(1, 16'hFFF1, 0, m[2:0]);  // saturation at unsigned top
      step(1, 16'hFFD8, 0, m[2:0]);  // same bits, unsigned view
      step(0, 16'h1234, 1, 3'd0);    // idle: hold
    end
    for (int i = 0; i < 4000; i++) begin
      d = DW'($urandom);
      case ($urandom % 8)
        0: d = {d[DW-1:DR], 1'b1, {(DR-1){1'b0}}};      // exact tie
        1: d = {1'b0, {(OW-1){1'b1}}, d[DR-1:0]};       // near signed top
        default: ;
      endcase
      step(($urandom % 5) != 0, d, 1'($urandom), 3'($urandom));
    end
    step(0, '0, 0, 3'd0);
    step(0, '0, 0, 3'd0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule